// File: doc/BRIEF.md
# Secure Cache-Array Debug Readout Unit

This block lets a debug agent read a single entry out of any of fifteen internal cache, TLB and predictor arrays. A 32-bit command word names the array, the way and the row. After a fixed two-cycle delay the block loads the result into a 128-bit readout set. The set is seen as four 32-bit words, and there is one set for the instruction side and one for the data side. A one-cycle `done` pulse marks the load.

Each stored entry has a valid flag, a non-secure flag and a 128-bit payload. What a requester may see depends on its security state and privilege level. Secure requesters, and any requester at the highest privilege level, see entries exactly as stored. Non-secure requesters at the two middle levels see only entries that are both valid and non-secure. They see every other entry, and the whole branch target array, as zeros.

Small behavioural arrays stand in for the real RAMs. A preload port fills them, using the same address decode as the command.

Top module: `dbg_array_reader`

## Requirements
- R1: The command word holds the array identifier in [31:24], a reserved field in [23:22], the way in [21:18] and the row index in [17:0]. Valid identifiers are 0x00 (I-tag), 0x01 (I-data), 0x02 (branch target), 0x03 (global history), 0x04 (I-TLB), 0x05 (indirect predictor), 0x08 (D-tag), 0x09 (D-data), 0x0A (D-TLB), 0x10 to 0x14 (second-level tag, data, snoop tag, data check bits, dirty) and 0x18 (second-level TLB).
- R2: Identifiers below 0x08 load `i_rdout`, and all others load `d_rdout`. The other readout set keeps its value.
- R3: After reset both readout sets are zero and `done`, `err` and `drop` are low. An accepted command raises `done` for one cycle, two rising edges after the edge that accepted it, together with the updated readout.
- R4: A `cmd_we` in the cycle after an accepted command is ignored. `drop` pulses alongside the pending `done`, and no second `done` follows.
- R5: A secure requester, or any requester with `req_el` = 3, receives the entry unfiltered.
- R6: A non-secure requester at `req_el` 1 or 2 receives the entry only if it is both valid and non-secure. Otherwise the readout is all zeros.
- R7: For that same restricted requester, identifier 0x02 always reads as zeros.
- R8: On identifiers 0x00 and 0x01, a way value of 3 addresses way 2. This applies to commands and preloads.
- R9: I-tag readout: word 1 = {30 zeros, valid, non-secure} and word 0 = payload[31:0]. Words 3 and 2 are zero.
- R10: D-tag readout: word 1 = {30 zeros, payload[33:32]} (a 2-bit coherence state), and word 0 = {0, non-secure, payload[29:0]}. Words 3 and 2 are zero.
- R11: Every other array returns its 128-bit payload. Word k sits at bits [32k+31:32k], so word 3 is the most significant.
- R12: Any of the following loads both readout sets with 0xDEAD_C0DE in every word and raises `err` together with `done`:
  - an unlisted identifier;
  - a nonzero reserved field;
  - a way at or above `NWAYS`;
  - an index at or above `DEPTH`;
  - `req_el` = 0.
- R13: A preload with a listed identifier and an in-range way and index stores the valid flag, the non-secure flag and the payload. A later command to that entry returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe |
| cmd_word | input | 32 | Array-select command |
| req_secure | input | 1 | Requester is in secure state |
| req_el | input | 2 | Requester privilege level, 0 to 3 |
| pl_we | input | 1 | Preload write strobe |
| pl_id | input | 8 | Preload array identifier |
| pl_way | input | 4 | Preload way |
| pl_idx | input | 18 | Preload row index |
| pl_valid | input | 1 | Preload entry valid flag |
| pl_ns | input | 1 | Preload entry non-secure flag |
| pl_data | input | 128 | Preload payload |
| i_rdout | output | 128 | Instruction-side readout words 3..0 |
| d_rdout | output | 128 | Data-side readout words 3..0 |
| done | output | 1 | Readout updated this cycle |
| err | output | 1 | Command was malformed or not permitted |
| drop | output | 1 | A busy-time command was discarded |

## Verification
The assertions assume three things about the inputs. Every entry a command reads has already been preloaded, so the behavioural arrays never return unwritten contents. Preload writes never overlap a command's array read. `req_el` and `req_secure` stay steady while `cmd_we` is high. The stimulus meets all three: it preloads every way and row of every listed array first, then issues commands. It holds the requester inputs with the command word until the strobe drops. It reuses ways 0 to 2 of the I-cache arrays only through the way-3 folding path.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int          NSLOTS      = 15;
    localparam int          SLOT_W      = 4;
    localparam logic [31:0] POISON_WORD = 32'hDEAD_C0DE;

    typedef enum logic [1:0] {
        K_RAW  = 2'd0,
        K_ITAG = 2'd1,
        K_DTAG = 2'd2,
        K_BTB  = 2'd3
    } kind_e;

    typedef struct packed {
        logic              known;
        logic [SLOT_W-1:0] slot;
        kind_e             kind;
        logic              dside;
        logic              icache;
    } arr_info_t;

    typedef struct packed {
        logic  bad;
        logic  dside;
        logic  restricted;
        kind_e kind;
    } cmd_info_t;

    typedef struct packed {
        logic         valid;
        logic         ns;
        logic [127:0] data;
    } entry_t;

    function automatic arr_info_t lookup_array(input logic [7:0] id);
        arr_info_t r;
        r.known  = 1'b1;
        r.slot   = 4'd0;
        r.kind   = K_RAW;
        r.dside  = 1'b0;
        r.icache = 1'b0;
        case (id)
            8'h00: begin r.slot = 4'd0;  r.kind = K_ITAG; r.icache = 1'b1; end
            8'h01: begin r.slot = 4'd1;  r.icache = 1'b1; end
            8'h02: begin r.slot = 4'd2;  r.kind = K_BTB; end
            8'h03: r.slot = 4'd3;
            8'h04: r.slot = 4'd4;
            8'h05: r.slot = 4'd5;
            8'h08: begin r.slot = 4'd6;  r.kind = K_DTAG; r.dside = 1'b1; end
            8'h09: begin r.slot = 4'd7;  r.dside = 1'b1; end
            8'h0A: begin r.slot = 4'd8;  r.dside = 1'b1; end
            8'h10: begin r.slot = 4'd9;  r.dside = 1'b1; end
            8'h11: begin r.slot = 4'd10; r.dside = 1'b1; end
            8'h12: begin r.slot = 4'd11; r.dside = 1'b1; end
            8'h13: begin r.slot = 4'd12; r.dside = 1'b1; end
            8'h14: begin r.slot = 4'd13; r.dside = 1'b1; end
            8'h18: begin r.slot = 4'd14; r.dside = 1'b1; end
            default: r.known = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [127:0] poison_line();
        return {4{POISON_WORD}};
    endfunction

endpackage

// File: rtl/dar_decode.sv
module dar_decode
    import dar_pkg::*;
#(
    parameter int NWAYS  = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 9
) (
    input  logic [31:0]       word,
    input  logic              secure,
    input  logic [1:0]        el,
    output cmd_info_t         info,
    output logic [ADDR_W-1:0] addr
);
    logic [7:0]  id_f;
    logic [1:0]  rsv_f;
    logic [3:0]  way_f;
    logic [3:0]  way_eff;
    logic [17:0] idx_f;
    arr_info_t   ai;
    int          flat;

    always_comb begin
        id_f  = word[31:24];
        rsv_f = word[23:22];
        way_f = word[21:18];
        idx_f = word[17:0];
        ai    = lookup_array(id_f);

        // the three-way I-cache folds way 3 onto way 2
        way_eff = (ai.icache && way_f == 4'd3) ? 4'd2 : way_f;

        info.bad = !ai.known || (rsv_f != 2'b00) ||
                   (int'(way_eff) >= NWAYS) || (int'(idx_f) >= DEPTH) ||
                   (el == 2'd0);
        info.dside      = ai.dside;
        info.kind       = ai.kind;
        info.restricted = !secure && (el != 2'd3);

        flat = (int'(ai.slot) * NWAYS + int'(way_eff)) * DEPTH + int'(idx_f);
        addr = info.bad ? '0 : ADDR_W'(flat);
    end
endmodule

// File: rtl/dar_store.sv
module dar_store
    import dar_pkg::*;
#(
    parameter int ENTRIES = 480,
    parameter int ADDR_W  = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  entry_t            wr_entry,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output entry_t            rd_entry
);
    entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_entry <= mem[rd_addr];
    end
endmodule

// File: rtl/dar_filter.sv
module dar_filter
    import dar_pkg::*;
(
    input  entry_t       ent,
    input  cmd_info_t    info,
    output logic [127:0] line
);
    logic [127:0] shaped;
    logic         hidden;

    always_comb begin
        unique case (info.kind)
            K_ITAG:  shaped = {64'b0, 30'b0, ent.valid, ent.ns, ent.data[31:0]};
            K_DTAG:  shaped = {64'b0, 30'b0, ent.data[33:32],
                               1'b0, ent.ns, ent.data[29:0]};
            default: shaped = ent.data;
        endcase
        hidden = info.restricted &&
                 ((info.kind == K_BTB) || !(ent.valid && ent.ns));
        line   = hidden ? '0 : shaped;
    end
endmodule

// File: rtl/dbg_array_reader.sv
module dbg_array_reader
    import dar_pkg::*;
#(
    parameter int NWAYS = 4,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_we,
    input  logic [31:0]  cmd_word,
    input  logic         req_secure,
    input  logic [1:0]   req_el,
    input  logic         pl_we,
    input  logic [7:0]   pl_id,
    input  logic [3:0]   pl_way,
    input  logic [17:0]  pl_idx,
    input  logic         pl_valid,
    input  logic         pl_ns,
    input  logic [127:0] pl_data,
    output logic [127:0] i_rdout,
    output logic [127:0] d_rdout,
    output logic         done,
    output logic         err,
    output logic         drop
);
    localparam int ENTRIES = NSLOTS * NWAYS * DEPTH;
    localparam int ADDR_W  = $clog2(ENTRIES);

    cmd_info_t         c_info, p_info, s1_info;
    logic [ADDR_W-1:0] c_addr, p_addr;
    logic              s1_vld, accept;
    entry_t            rd_entry, wr_entry;
    logic [127:0]      line;

    assign accept   = cmd_we && !s1_vld;
    assign wr_entry = '{valid: pl_valid, ns: pl_ns, data: pl_data};

    dar_decode #(.NWAYS(NWAYS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cmd_dec (
        .word(cmd_word), .secure(req_secure), .el(req_el),
        .info(c_info), .addr(c_addr)
    );

    dar_decode #(.NWAYS(NWAYS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pl_dec (
        .word({pl_id, 2'b00, pl_way, pl_idx}), .secure(1'b1), .el(2'd3),
        .info(p_info), .addr(p_addr)
    );

    dar_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
        .clk(clk),
        .wr_en(pl_we && !p_info.bad), .wr_addr(p_addr), .wr_entry(wr_entry),
        .rd_en(accept), .rd_addr(c_addr), .rd_entry(rd_entry)
    );

    dar_filter u_filter (.ent(rd_entry), .info(s1_info), .line(line));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_info <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            drop    <= 1'b0;
            i_rdout <= '0;
            d_rdout <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) s1_info <= c_info;
            done <= s1_vld;
            err  <= s1_vld && s1_info.bad;
            drop <= cmd_we && s1_vld;
            if (s1_vld) begin
                if (s1_info.bad) begin
                    i_rdout <= poison_line();
                    d_rdout <= poison_line();
                end else if (s1_info.dside) begin
                    d_rdout <= line;
                end else begin
                    i_rdout <= line;
                end
            end
        end
    end

    // R3: fixed latency, single-cycle pulse
    a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 done);
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4: a discard only happens while a result is landing
    a_r4_drop_with_done: assert property (@(posedge clk) disable iff (rst)
        drop |-> done);
    // R12: error flag and poison travel with done
    a_r12_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
    a_r12_poison_both: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (i_rdout == poison_line() && d_rdout == poison_line()));
    // R6: hidden entries reach the register stage as zeros
    a_r6_hidden_zero: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !s1_info.bad && s1_info.restricted &&
         !(rd_entry.valid && rd_entry.ns)) |-> (line == '0));
    // R7: branch target array is blank for restricted requesters
    a_r7_btb_zero: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_info.restricted && s1_info.kind == K_BTB) |-> (line == '0));
    // R2: a data-side result leaves the instruction-side set alone
    a_r2_side_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !err && $past(s1_info.dside)) |-> $stable(i_rdout));

endmodule

// File: tb/tb_dbg_array_reader.sv
module tb_dbg_array_reader;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int DP = 8;
    localparam logic [31:0] PW = 32'hDEAD_C0DE;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_we = 1'b0;
    logic [31:0]  cmd_word = '0;
    logic         req_secure = 1'b1;
    logic [1:0]   req_el = 2'd3;
    logic         pl_we = 1'b0;
    logic [7:0]   pl_id = '0;
    logic [3:0]   pl_way = '0;
    logic [17:0]  pl_idx = '0;
    logic         pl_valid = 1'b0;
    logic         pl_ns = 1'b0;
    logic [127:0] pl_data = '0;
    logic [127:0] i_rdout, d_rdout;
    logic         done, err, drop;

    int n_cmp = 0;
    int n_bad = 0;
    logic [127:0] exp_i = '0;
    logic [127:0] exp_d = '0;

    dbg_array_reader #(.NWAYS(NW), .DEPTH(DP)) dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .req_secure(req_secure), .req_el(req_el),
        .pl_we(pl_we), .pl_id(pl_id), .pl_way(pl_way), .pl_idx(pl_idx),
        .pl_valid(pl_valid), .pl_ns(pl_ns), .pl_data(pl_data),
        .i_rdout(i_rdout), .d_rdout(d_rdout), .done(done), .err(err), .drop(drop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, got no finish, expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic bit listed(input logic [7:0] id);
        return (id <= 8'h05) || (id >= 8'h08 && id <= 8'h0A) ||
               (id >= 8'h10 && id <= 8'h14) || (id == 8'h18);
    endfunction

    function automatic logic [127:0] pattern(input logic [7:0] id, input int w, input int ix);
        logic [127:0] r;
        for (int k = 0; k < 4; k++)
            r[32*k +: 32] = {id, 4'(w), 4'(k), 8'(ix), 8'(ix*29 + w*7 + k*3 + int'(id))};
        return r;
    endfunction

    function automatic logic vflag(input int ix); return ~ix[1]; endfunction
    function automatic logic nflag(input int ix); return ix[0];   endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input logic [127:0] got, input logic [127:0] want);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s got %h expected %h", req, what, got, want);
        end
    endtask

    task automatic run_cmd(input string req, input logic [7:0] id, input logic [1:0] rsv,
                           input int w, input int ix, input logic sec, input logic [1:0] el);
        logic [127:0] raw, line;
        logic         v, n, bad, restr;
        int           we;
        we    = (id <= 8'h01 && w == 3) ? 2 : w;
        bad   = !listed(id) || rsv != 0 || we >= NW || ix >= DP || el == 0;
        restr = !sec && el != 3;
        if (bad) begin
            exp_i = {4{PW}}; exp_d = {4{PW}};
        end else begin
            raw = pattern(id, we, ix); v = vflag(ix); n = nflag(ix);
            if (id == 8'h00)      line = {64'b0, 30'b0, v, n, raw[31:0]};
            else if (id == 8'h08) line = {64'b0, 30'b0, raw[33:32], 1'b0, n, raw[29:0]};
            else                  line = raw;
            if (restr && (id == 8'h02 || !(v && n))) line = '0;
            if (id >= 8'h08) exp_d = line; else exp_i = line;
        end
        @(negedge clk);
        cmd_we = 1'b1; cmd_word = {id, rsv, 4'(w), 18'(ix)};
        req_secure = sec; req_el = el;
        @(negedge clk);
        cmd_we = 1'b0;
        @(negedge clk);
        check(req, done && !drop && err == bad, "done/drop/err",
              {125'b0, done, drop, err}, {125'b0, 1'b1, 1'b0, bad});
        check(req, i_rdout == exp_i && d_rdout == exp_d, "i_rdout,d_rdout (R2 side)",
              i_rdout ^ d_rdout, exp_i ^ exp_d);
        if (i_rdout != exp_i || d_rdout != exp_d)
            $display("  detail id=%h way=%0d idx=%0d i=%h/%h d=%h/%h",
                     id, w, ix, i_rdout, exp_i, d_rdout, exp_d);
    endtask

    function automatic string tag_for(input logic [7:0] id, input int w, input logic sec);
        if (id == 8'h02 && !sec) return "R7";
        if (id <= 8'h01 && w == 3) return "R8";
        if (id == 8'h00) return "R9";
        if (id == 8'h08) return "R10";
        return sec ? "R5 R11 R13" : "R6";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        check("R3", i_rdout == 0 && d_rdout == 0 && !done && !err && !drop,
              "reset state", i_rdout | d_rdout, '0);

        // R13 preload every entry of every listed array
        for (int id = 0; id < 256; id++) begin
            if (!listed(8'(id))) continue;
            for (int w = 0; w < NW; w++) begin
                if (id <= 1 && w == 3) continue;
                for (int ix = 0; ix < DP; ix++) begin
                    @(negedge clk);
                    pl_we = 1'b1; pl_id = 8'(id); pl_way = 4'(w); pl_idx = 18'(ix);
                    pl_valid = vflag(ix); pl_ns = nflag(ix);
                    pl_data = pattern(8'(id), w, ix);
                end
            end
        end
        @(negedge clk);
        pl_we = 1'b0;

        // full sweep, secure and restricted views
        for (int id = 0; id < 256; id++) begin
            if (!listed(8'(id))) continue;
            for (int w = 0; w < NW; w++)
                for (int ix = 0; ix < DP; ix++) begin
                    run_cmd(tag_for(8'(id), w, 1'b1), 8'(id), 2'b00, w, ix, 1'b1, 2'd1);
                    run_cmd(tag_for(8'(id), w, 1'b0), 8'(id), 2'b00, w, ix, 1'b0, 2'd1);
                end
        end

        // other privilege views on one array
        for (int ix = 0; ix < DP; ix++) begin
            run_cmd("R6", 8'h11, 2'b00, 1, ix, 1'b0, 2'd2);
            run_cmd("R5", 8'h11, 2'b00, 1, ix, 1'b0, 2'd3);
            run_cmd("R7", 8'h02, 2'b00, 0, ix, 1'b0, 2'd2);
        end

        // R1 / R12 reserved identifiers
        for (int id = 0; id < 256; id++)
            if (!listed(8'(id))) run_cmd("R1 R12", 8'(id), 2'b00, 0, 0, 1'b1, 2'd3);

        // R12 other malformed cases
        run_cmd("R12", 8'h09, 2'b01, 0, 0, 1'b1, 2'd3);
        run_cmd("R12", 8'h09, 2'b10, 0, 0, 1'b1, 2'd3);
        run_cmd("R12", 8'h09, 2'b00, NW, 0, 1'b1, 2'd3);
        run_cmd("R12", 8'h10, 2'b00, 15, 0, 1'b1, 2'd3);
        run_cmd("R12", 8'h09, 2'b00, 0, DP, 1'b1, 2'd3);
        run_cmd("R12", 8'h09, 2'b00, 0, 18'h3FFFF, 1'b1, 2'd3);
        run_cmd("R12", 8'h09, 2'b00, 0, 0, 1'b1, 2'd0);
        run_cmd("R12", 8'h00, 2'b00, 0, 0, 1'b0, 2'd0);
        run_cmd("R2", 8'h00, 2'b00, 1, 4, 1'b1, 2'd3);
        run_cmd("R2", 8'h14, 2'b00, 2, 5, 1'b1, 2'd3);

        // R4 command during busy is dropped
        exp_d = pattern(8'h09, 1, 2);
        @(negedge clk);
        cmd_we = 1'b1; cmd_word = {8'h09, 2'b00, 4'd1, 18'd2};
        req_secure = 1'b1; req_el = 2'd3;
        @(negedge clk);
        cmd_word = {8'h10, 2'b00, 4'd0, 18'd0};
        @(negedge clk);
        cmd_we = 1'b0;
        check("R4", done && drop && !err, "done/drop/err on busy",
              {125'b0, done, drop, err}, {125'b0, 3'b110});
        check("R4", d_rdout == exp_d && i_rdout == exp_i, "first result kept",
              d_rdout, exp_d);
        @(negedge clk);
        check("R4", !done && !drop, "no second done",
              {126'b0, done, drop}, '0);
        check("R4", d_rdout == exp_d, "dropped command left data", d_rdout, exp_d);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule